// File: doc/BRIEF.md
# Banked Registered-Read Translation Table

This block is the storage array that sits under a first-level address translation cache. Each entry holds one translation result: a physical page number together with its permission bits. A requester presents an entry index on the read port and gets the stored translation exactly one clock later. A single write port fills or overwrites entries. Tag compare, victim choice and page walking live outside the block.

The array is split into equal banks. The upper index bits pick the bank and the lower bits pick the row inside it. Every bank is read combinationally at the row offset, and each bank's result is captured in its own register. The bank chosen by the registered upper index bits is selected after those registers. This keeps the capture flops close to the storage and moves the wide multiplexer to the far side of the clock edge. The selected entry is produced separately for each of a parameterised number of output copies, so that consumers placed far apart each get a private copy. When the write and the read address the same entry in the same cycle, the read returns the data being written.

The read request is a valid-only stream with no back-pressure. The latency is fixed at one clock and there is no storage to absorb a stall, so every consumer must take the response in the cycle its valid is high. When no read is requested, the outputs hold the last response.

Top module: `xlat_tbl`

## Requirements
- R1: While reset is asserted and on the first edges after it, every response valid is low and every copy's page number and permission fields are zero. All stored entries reset to zero, so a read of any index returns zero until that entry is written.
- R2: A read request sampled on a clock edge gives, on the following edge, response valid high and the entry stored at that index on every copy.
- R3: Index bits above the row offset select the bank, and the lower bits select the row inside it. A write changes only the addressed entry, including entries in other banks at the same row.
- R4: When a write and a read use the same full index in the same cycle, the response carries the data being written.
- R5: When a write and a read use different indices in the same cycle, the response carries the value stored before that edge.
- R6: All copies carry identical valid, page number and permission values and change on the same edge. Copy k occupies bits [k*PPN_W +: PPN_W] of the page-number output, bits [k*PERM_W +: PERM_W] of the permission output and bit k of the valid output.
- R7: Response valid is high in exactly the cycles that follow a sampled read request. In a cycle with no read request, the data outputs keep their previous values.
- R8: With write enable low, the write index and data have no effect on any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | IDX_W | Entry index to write |
| wr_ppn_i | input | PPN_W | Physical page number to write |
| wr_perm_i | input | PERM_W | Permission bits to write |
| rd_valid_i | input | 1 | Read request valid |
| rd_idx_i | input | IDX_W | Entry index to read |
| rsp_valid_o | output | COPIES | Response valid, one bit per copy |
| rsp_ppn_o | output | COPIES*PPN_W | Page number, one field per copy |
| rsp_perm_o | output | COPIES*PERM_W | Permission bits, one field per copy |

## Verification
A registered bank-select value that does not belong to the same request as the captured bank data shows up on the next response as a valid entry from the wrong bank at the right row. A broken bypass shows up as stale data in the very cycle after a colliding write and read. A corrupt store write shows up only when that entry is next read, which can be many cycles later. The random traffic therefore reads indices that were written long before, and also forces same-index and same-row collisions. A copy whose select path has diverged shows up as a mismatch between copies on the first response after the fault.

// File: rtl/xlat_tbl_pkg.sv
package xlat_tbl_pkg;
  parameter int PPN_W  = 20;
  parameter int PERM_W = 8;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
  } xlat_entry_t;
endpackage

// File: rtl/xlat_bank.sv
module xlat_bank
  import xlat_tbl_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int OFF_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  xlat_entry_t       wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output xlat_entry_t       rd_data_o
);
  xlat_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_off_i] <= wr_data_i;
    end
  end

  // asynchronous read; an entry being written this cycle is forwarded
  always_comb begin
    if (wr_en_i && (wr_off_i == rd_off_i)) rd_data_o = wr_data_i;
    else                                   rd_data_o = mem[rd_off_i];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> mem[$past(wr_off_i)] == $past(wr_data_i)); // R2
endmodule

// File: rtl/xlat_pick.sv
module xlat_pick
  import xlat_tbl_pkg::*;
#(
  parameter int BANKS = 4,
  localparam int BSEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  xlat_entry_t [BANKS-1:0] bank_q_i,
  input  logic [BSEL_W-1:0]       sel_q_i,
  output xlat_entry_t             pick_o
);
  always_comb begin
    pick_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (sel_q_i == BSEL_W'(b)) pick_o = bank_q_i[b];
    end
  end
endmodule

// File: rtl/xlat_tbl.sv
module xlat_tbl
  import xlat_tbl_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BANKS   = 4,
  parameter int COPIES  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [PPN_W-1:0]           wr_ppn_i,
  input  logic [PERM_W-1:0]          wr_perm_i,
  input  logic                       rd_valid_i,
  input  logic [IDX_W-1:0]           rd_idx_i,
  output logic [COPIES-1:0]          rsp_valid_o,
  output logic [COPIES*PPN_W-1:0]    rsp_ppn_o,
  output logic [COPIES*PERM_W-1:0]   rsp_perm_o
);
  localparam int BSEL_W = $clog2(BANKS);
  localparam int DEPTH  = ENTRIES / BANKS;
  localparam int OFF_W  = IDX_W - BSEL_W;

  logic [BSEL_W-1:0] wr_bank, rd_bank;
  logic [OFF_W-1:0]  wr_off, rd_off;
  xlat_entry_t       wr_data;
  logic [BANKS-1:0]  bank_we;
  xlat_entry_t [BANKS-1:0] bank_rd;
  xlat_entry_t [BANKS-1:0] bank_q;
  logic [BSEL_W-1:0] sel_q;
  logic              vld_q;

  assign wr_bank = wr_idx_i[IDX_W-1 -: BSEL_W];
  assign rd_bank = rd_idx_i[IDX_W-1 -: BSEL_W];
  assign wr_off  = wr_idx_i[OFF_W-1:0];
  assign rd_off  = rd_idx_i[OFF_W-1:0];
  assign wr_data = '{ppn: wr_ppn_i, perm: wr_perm_i};

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_we[b] = wr_en_i && (wr_bank == BSEL_W'(b));

    xlat_bank #(.DEPTH(DEPTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (bank_we[b]),
      .wr_off_i  (wr_off),
      .wr_data_i (wr_data),
      .rd_off_i  (rd_off),
      .rd_data_o (bank_rd[b])
    );

    // per-bank capture flop, loaded only on a read request
    always_ff @(posedge clk) begin
      if (!rst_n)          bank_q[b] <= '0;
      else if (rd_valid_i) bank_q[b] <= bank_rd[b];
    end
  end

  // bank select travels with the captured data of the same request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_valid_i;
      if (rd_valid_i) sel_q <= rd_bank;
    end
  end

  // one private post-register selector per output copy
  for (genvar k = 0; k < COPIES; k++) begin : g_copy
    xlat_entry_t pick;

    xlat_pick #(.BANKS(BANKS)) u_pick (
      .bank_q_i (bank_q),
      .sel_q_i  (sel_q),
      .pick_o   (pick)
    );

    assign rsp_valid_o[k]                  = vld_q;
    assign rsp_ppn_o[k*PPN_W +: PPN_W]     = pick.ppn;
    assign rsp_perm_o[k*PERM_W +: PERM_W]  = pick.perm;

    AST_COPY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_ppn_o[k*PPN_W +: PPN_W] == rsp_ppn_o[PPN_W-1:0]) &&
      (rsp_perm_o[k*PERM_W +: PERM_W] == rsp_perm_o[PERM_W-1:0])); // R6
  end

  AST_ONE_BANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we)); // R3
  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |-> (bank_we == '0)); // R8
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i |=> rsp_valid_o[0]); // R7
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> !rsp_valid_o[0]); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_i |=> ($stable(rsp_ppn_o) && $stable(rsp_perm_o))); // R7
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_i && wr_en_i && (wr_idx_i == rd_idx_i)) |=>
      (rsp_ppn_o[PPN_W-1:0] == $past(wr_ppn_i)) &&
      (rsp_perm_o[PERM_W-1:0] == $past(wr_perm_i))); // R4
endmodule

// File: tb/xlat_tbl_tb.sv
module xlat_tbl_tb_top;
  import xlat_tbl_pkg::*;

  localparam int ENTRIES = 32;
  localparam int BANKS   = 4;
  localparam int COPIES  = 3;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int ROWS    = ENTRIES / BANKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic [PERM_W-1:0] wr_perm = '0;
  logic rd_valid = 1'b0;
  logic [IDX_W-1:0] rd_idx = '0;
  logic [COPIES-1:0] rsp_valid;
  logic [COPIES*PPN_W-1:0] rsp_ppn;
  logic [COPIES*PERM_W-1:0] rsp_perm;

  always #4 clk = ~clk;  // 125 MHz

  xlat_tbl #(.ENTRIES(ENTRIES), .BANKS(BANKS), .COPIES(COPIES)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_ppn_i(wr_ppn), .wr_perm_i(wr_perm),
    .rd_valid_i(rd_valid), .rd_idx_i(rd_idx),
    .rsp_valid_o(rsp_valid), .rsp_ppn_o(rsp_ppn), .rsp_perm_o(rsp_perm)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [PPN_W-1:0]  ref_ppn  [ENTRIES];
  logic [PERM_W-1:0] ref_perm [ENTRIES];
  logic              exp_v    = 1'b0;
  logic [PPN_W-1:0]  exp_ppn  = '0;
  logic [PERM_W-1:0] exp_perm = '0;
  string             exp_tag  = "R1";

  // expected response of a read issued together with an optional write
  function automatic logic [PPN_W+PERM_W-1:0] model_read(
      input logic w, input logic [IDX_W-1:0] wi, input logic [PPN_W-1:0] wp,
      input logic [PERM_W-1:0] wq, input logic [IDX_W-1:0] ri);
    if (w && wi == ri) return {wp, wq};
    return {ref_ppn[ri], ref_perm[ri]};
  endfunction

  task automatic check_outputs();
    for (int k = 0; k < COPIES; k++) begin
      logic gv;
      logic [PPN_W-1:0] gp;
      logic [PERM_W-1:0] gq;
      gv = rsp_valid[k];
      gp = rsp_ppn[k*PPN_W +: PPN_W];
      gq = rsp_perm[k*PERM_W +: PERM_W];
      checks++;
      if (gv !== exp_v) begin
        fails++;
        $display("FAIL R7 copy %0d valid got %0b exp %0b", k, gv, exp_v);
      end
      checks++;
      if (gp !== exp_ppn || gq !== exp_perm) begin
        fails++;
        $display("FAIL %s (R6 copy %0d) data got %h/%h exp %h/%h",
                 exp_tag, k, gp, gq, exp_ppn, exp_perm);
      end
    end
  endtask

  // one cycle: check previous response, drive new inputs, update model
  task automatic step(input logic w, input logic [IDX_W-1:0] wi,
                      input logic [PPN_W-1:0] wp, input logic [PERM_W-1:0] wq,
                      input logic r, input logic [IDX_W-1:0] ri);
    logic [PPN_W+PERM_W-1:0] d;
    @(negedge clk);
    check_outputs();
    wr_en = w; wr_idx = wi; wr_ppn = wp; wr_perm = wq;
    rd_valid = r; rd_idx = ri;
    exp_v = r;
    if (r) begin
      d = model_read(w, wi, wp, wq, ri);
      {exp_ppn, exp_perm} = d;
      if (w && wi == ri)  exp_tag = "R4";
      else if (w)         exp_tag = "R5";
      else                exp_tag = "R2";
    end else begin
      exp_tag = "R7";
    end
    if (w) begin
      ref_ppn[wi] = wp;
      ref_perm[wi] = wq;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < ENTRIES; i++) begin
      ref_ppn[i] = '0;
      ref_perm[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_outputs();            // R1: reset state
    rst_n = 1'b1;

    // R1: every entry reads zero before being written
    for (int i = 0; i < ENTRIES; i++) begin
      step(1'b0, '0, '0, '0, 1'b1, IDX_W'(i));
      exp_tag = "R1";
    end

    // R8: write data presented with enable low leaves entry 5 at zero
    step(1'b0, 5'd5, 20'hABCDE, 8'h5A, 1'b0, '0);
    step(1'b0, '0, '0, '0, 1'b1, 5'd5);
    exp_tag = "R8";

    // R3: same row, different banks stay independent
    for (int b = 0; b < BANKS; b++)
      step(1'b1, IDX_W'(b*ROWS + 2), PPN_W'(32'h1000 + b), PERM_W'(b + 1), 1'b0, '0);
    for (int b = 0; b < BANKS; b++) begin
      step(1'b0, '0, '0, '0, 1'b1, IDX_W'(b*ROWS + 2));
      exp_tag = "R3";
    end

    // R4: same-index collision; R5: same row other bank collision
    step(1'b1, 5'd10, 20'h77777, 8'hC3, 1'b1, 5'd10);
    step(1'b1, 5'd18, 20'h12345, 8'h0F, 1'b1, 5'd10);
    // R7: idle cycles hold the last response
    step(1'b1, 5'd3, 20'h55555, 8'hAA, 1'b0, '0);
    step(1'b0, '0, '0, '0, 1'b0, '0);

    // constrained random traffic with forced collisions
    for (int n = 0; n < 4000; n++) begin
      logic w, r;
      logic [IDX_W-1:0] wi, ri;
      int mode;
      w  = ($urandom % 100) < 50;
      r  = ($urandom % 100) < 70;
      wi = IDX_W'($urandom);
      mode = $urandom % 10;
      if (mode < 2)      ri = wi;
      else if (mode < 4) ri = {IDX_W'($urandom)} ^ (wi & IDX_W'(ROWS - 1)) & ~IDX_W'(ROWS - 1) | (wi & IDX_W'(ROWS - 1));
      else               ri = IDX_W'($urandom);
      step(w, wi, PPN_W'($urandom), PERM_W'($urandom), r, ri);
    end
    step(1'b0, '0, '0, '0, 1'b0, '0);
    @(negedge clk);
    check_outputs();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule